// File: doc/BRIEF.md
# Programmable Video Blanking and Sync Timer

This block produces the raster timing for an interlaced composite video output from a single pixel clock. A pixel counter walks each line and a line counter walks each field. The block decodes horizontal sync, a color-burst gate, vertical sync and an active-video enable from those counters against a set of programmable timing values. Line length, sync width, burst placement, blanking offsets, active pixel and line counts, lines per field and vertical sync duration are all programmable. A field flag alternates from field to field. In the second field the vertical sync starts half a line later, which gives the interlace offset.

The active window is placed by offsets measured from the start of the line and from the start of the field. Forced blanking overrides that window in two places. The first runs from the start of horizontal sync to the end of the burst gate. The second covers the whole vertical sync interval. Because of this, badly chosen window values can never put picture data into the sync or burst regions.

The timing values are held in shadow registers. These reload only when a field starts, so a field always runs on one consistent set of values.

Top module: `vtg_timer`

## Requirements
- R1: `pix_cnt` counts 0 to L-1 and then wraps to 0, where L is the line-length value. `line_cnt` advances by one at each pixel wrap and returns to 0 after the last line of the field (the lines-per-field value minus one).
- R2: `hsync` is 1 exactly when `pix_cnt` < the horizontal sync width.
- R3: `burst_gate` is 1 exactly when burst start <= `pix_cnt` < burst start + burst width, both counted from pixel 0 of the line.
- R4: With `cfg_vsync_3l` = 1, vertical sync lasts 3 lines, which is 6 half-lines. Take the half-line index h = 2*`line_cnt` + (`pix_cnt` >= floor(L/2)). Then `vsync` = 1 exactly when f <= h < f+6, where f is the current `field` value.
- R5: With `cfg_vsync_3l` = 0, vertical sync lasts 2.5 lines: `vsync` = 1 exactly when f <= h < f+5. In field 0 it therefore ends at pixel floor(L/2) of line 2.
- R6: `field` is 0 in the first field after reset and inverts each time a new field starts, at `pix_cnt` = 0 and `line_cnt` = 0. The vertical sync of field 1 starts at pixel floor(L/2) of line 0.
- R7: `blank` is 1 and `active` is 0 whenever `pix_cnt` < horizontal sync width or `pix_cnt` < burst start + burst width, whatever the window values are.
- R8: `blank` is 1 and `active` is 0 whenever `vsync` is 1.
- R9: `active` is 1 exactly when all of the following hold: horizontal offset <= `pix_cnt` < horizontal offset + active pixel count; vertical offset <= `line_cnt` < vertical offset + active line count; neither R7 nor R8 forces blanking. `blank` is always the inverse of `active`.
- R10: The timing inputs are sampled only at the clock edge that starts a field. A change made in the middle of a field has no effect on any output until the next field begins.
- R11: While `rst_n` is low, and until counting starts, the outputs are idle: `blank` = 1, all other flags 0, both counters 0 and `field` = 0. Counting starts on the third rising clock edge after `rst_n` rises, with `pix_cnt` = 0, `line_cnt` = 0 and `field` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_line_len | input | HW | Total pixels per line (L), at least 2 |
| cfg_hsync_w | input | HW | Horizontal sync width in pixels |
| cfg_burst_start | input | HW | First pixel of the burst gate |
| cfg_burst_w | input | HW | Burst gate width in pixels |
| cfg_hact_ofs | input | HW | First active pixel of a line |
| cfg_hact_len | input | HW | Number of active pixels per line |
| cfg_field_lines | input | VW | Lines per field, at least 4 |
| cfg_vact_ofs | input | VW | First active line of a field |
| cfg_vact_len | input | VW | Number of active lines per field |
| cfg_vsync_3l | input | 1 | 1: 3-line vertical sync; 0: 2.5-line vertical sync |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| burst_gate | output | 1 | Color-burst gate |
| blank | output | 1 | Video blanked |
| active | output | 1 | Active picture |
| field | output | 1 | Current field (0 or 1) |
| pix_cnt | output | HW | Pixel position within the line |
| line_cnt | output | VW | Line position within the field |

## Verification
The bench drives several small configurations and checks every output on every cycle of several whole fields.

- Odd line length. One configuration uses an odd line length, so the half-line split falls on a rounded-down pixel. A design that rounds the wrong way, or that ends a 2.5-line sync at a line boundary, gets the vsync edge wrong by a pixel or by half a line.
- Forced blanking regions. Some windows start inside the sync/burst region, extend past the end of the line, or cover the vertical sync lines. Other configurations have an empty window, or a horizontal sync wider than the burst end. If forced blanking does not override the window, `active` shows up in those regions.
- Mid-field reprogramming. The timing values are changed partway through a field. A design without field-boundary shadowing wraps its counters at the new length at once, and the per-cycle comparison catches that.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Vertical sync duration selector.
  typedef enum logic {
    VSD_2P5 = 1'b0,
    VSD_3   = 1'b1
  } vsync_dur_e;

  // Vertical sync length expressed in half-lines.
  localparam int unsigned VS_HALVES_SHORT = 5;
  localparam int unsigned VS_HALVES_LONG  = 6;

  // Number of synchronizer stages on reset release.
  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/vtg_rst_sync.sv
module vtg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/vtg_cfg_shadow.sv
module vtg_cfg_shadow #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] cfg_line_len,
  input  logic [HW-1:0] cfg_hsync_w,
  input  logic [HW-1:0] cfg_burst_start,
  input  logic [HW-1:0] cfg_burst_w,
  input  logic [HW-1:0] cfg_hact_ofs,
  input  logic [HW-1:0] cfg_hact_len,
  input  logic [VW-1:0] cfg_field_lines,
  input  logic [VW-1:0] cfg_vact_ofs,
  input  logic [VW-1:0] cfg_vact_len,
  input  logic          cfg_vsync_3l,
  output logic [HW-1:0] q_line_len,
  output logic [HW-1:0] q_hsync_w,
  output logic [HW-1:0] q_burst_start,
  output logic [HW-1:0] q_burst_w,
  output logic [HW-1:0] q_hact_ofs,
  output logic [HW-1:0] q_hact_len,
  output logic [VW-1:0] q_field_lines,
  output logic [VW-1:0] q_vact_ofs,
  output logic [VW-1:0] q_vact_len,
  output logic          q_vsync_3l
);

  localparam int unsigned NH = 6;
  localparam int unsigned NV = 3;

  logic [HW-1:0] h_in [NH];
  logic [HW-1:0] h_q  [NH];
  logic [HW-1:0] h_d  [NH];
  logic [VW-1:0] v_in [NV];
  logic [VW-1:0] v_q  [NV];
  logic [VW-1:0] v_d  [NV];
  logic          vs_q;
  logic          vs_d;

  assign h_in[0] = cfg_line_len;
  assign h_in[1] = cfg_hsync_w;
  assign h_in[2] = cfg_burst_start;
  assign h_in[3] = cfg_burst_w;
  assign h_in[4] = cfg_hact_ofs;
  assign h_in[5] = cfg_hact_len;
  assign v_in[0] = cfg_field_lines;
  assign v_in[1] = cfg_vact_ofs;
  assign v_in[2] = cfg_vact_len;

  // Horizontal timing fields: one enabled register each.
  for (genvar gi = 0; gi < NH; gi++) begin : g_hreg
    always_comb begin
      h_d[gi] = load ? h_in[gi] : h_q[gi];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        h_q[gi] <= '0;
      end else begin
        h_q[gi] <= h_d[gi];
      end
    end
  end

  // Vertical timing fields.
  for (genvar gv = 0; gv < NV; gv++) begin : g_vreg
    always_comb begin
      v_d[gv] = load ? v_in[gv] : v_q[gv];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[gv] <= '0;
      end else begin
        v_q[gv] <= v_d[gv];
      end
    end
  end

  always_comb begin
    vs_d = load ? cfg_vsync_3l : vs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q <= 1'b0;
    end else begin
      vs_q <= vs_d;
    end
  end

  assign q_line_len    = h_q[0];
  assign q_hsync_w     = h_q[1];
  assign q_burst_start = h_q[2];
  assign q_burst_w     = h_q[3];
  assign q_hact_ofs    = h_q[4];
  assign q_hact_len    = h_q[5];
  assign q_field_lines = v_q[0];
  assign q_vact_ofs    = v_q[1];
  assign q_vact_len    = v_q[2];
  assign q_vsync_3l    = vs_q;

endmodule

// File: rtl/vtg_counters.sv
module vtg_counters #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] q_line_len,
  input  logic [VW-1:0] q_field_lines,
  output logic          started,
  output logic          field_start,
  output logic [HW-1:0] pix,
  output logic [VW-1:0] line,
  output logic          field
);

  localparam logic [HW-1:0] H_ONE = {{(HW-1){1'b0}}, 1'b1};
  localparam logic [VW-1:0] V_ONE = {{(VW-1){1'b0}}, 1'b1};

  logic          started_q, started_d;
  logic [HW-1:0] pix_q, pix_d;
  logic [VW-1:0] line_q, line_d;
  logic          field_q, field_d;
  logic          pix_last;
  logic          line_last;
  logic          field_end;

  always_comb begin
    pix_last  = (pix_q == (q_line_len - H_ONE));
    line_last = (line_q == (q_field_lines - V_ONE));
    field_end = started_q && pix_last && line_last;
  end

  // Next-state logic for the raster position.
  always_comb begin
    started_d = 1'b1;
    pix_d     = pix_q;
    line_d    = line_q;
    field_d   = field_q;
    if (!started_q) begin
      pix_d   = '0;
      line_d  = '0;
      field_d = 1'b0;
    end else if (pix_last) begin
      pix_d = '0;
      if (line_last) begin
        line_d  = '0;
        field_d = ~field_q;
      end else begin
        line_d = line_q + V_ONE;
      end
    end else begin
      pix_d = pix_q + H_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      pix_q     <= '0;
      line_q    <= '0;
      field_q   <= 1'b0;
    end else begin
      started_q <= started_d;
      pix_q     <= pix_d;
      line_q    <= line_d;
      field_q   <= field_d;
    end
  end

  // Shadow reload request: first start, and every field boundary.
  assign field_start = !started_q || field_end;
  assign started     = started_q;
  assign pix         = pix_q;
  assign line        = line_q;
  assign field       = field_q;

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 10
) (
  input  logic          started,
  input  logic [HW-1:0] pix,
  input  logic [VW-1:0] line,
  input  logic          field,
  input  logic [HW-1:0] q_line_len,
  input  logic [HW-1:0] q_hsync_w,
  input  logic [HW-1:0] q_burst_start,
  input  logic [HW-1:0] q_burst_w,
  input  logic [HW-1:0] q_hact_ofs,
  input  logic [HW-1:0] q_hact_len,
  input  logic [VW-1:0] q_vact_ofs,
  input  logic [VW-1:0] q_vact_len,
  input  logic          q_vsync_3l,
  output logic          hsync,
  output logic          vsync,
  output logic          burst_gate,
  output logic          blank,
  output logic          active
);

  localparam int unsigned HX = HW + 1;
  localparam int unsigned VX = VW + 1;
  localparam int unsigned HL = VW + 2;

  logic [HW-1:0] half_len;
  logic          past_half;
  logic [HL-1:0] half_idx;
  logic [HL-1:0] vs_first;
  logic [HL-1:0] vs_len;
  logic [HL-1:0] vs_stop;
  logic [HX-1:0] pix_x;
  logic [HX-1:0] burst_stop;
  logic [HX-1:0] hact_stop;
  logic [VX-1:0] line_x;
  logic [VX-1:0] vact_stop;
  logic          hs_win, burst_win, hforce, vs_win, h_win, v_win;

  // Half-line position within the field.
  always_comb begin
    half_len  = {1'b0, q_line_len[HW-1:1]};
    past_half = (pix >= half_len);
    half_idx  = {1'b0, line, past_half};
    vs_first  = {{(HL-1){1'b0}}, field};
    vs_len    = (vsync_dur_e'(q_vsync_3l) == VSD_3) ? HL'(VS_HALVES_LONG)
                                                    : HL'(VS_HALVES_SHORT);
    vs_stop   = vs_first + vs_len;
    vs_win    = (half_idx >= vs_first) && (half_idx < vs_stop);
  end

  // Horizontal windows.
  always_comb begin
    pix_x      = {1'b0, pix};
    burst_stop = {1'b0, q_burst_start} + {1'b0, q_burst_w};
    hact_stop  = {1'b0, q_hact_ofs} + {1'b0, q_hact_len};
    hs_win     = (pix < q_hsync_w);
    burst_win  = (pix >= q_burst_start) && (pix_x < burst_stop);
    hforce     = hs_win || (pix_x < burst_stop);
    h_win      = (pix >= q_hact_ofs) && (pix_x < hact_stop);
  end

  // Vertical window.
  always_comb begin
    line_x    = {1'b0, line};
    vact_stop = {1'b0, q_vact_ofs} + {1'b0, q_vact_len};
    v_win     = (line >= q_vact_ofs) && (line_x < vact_stop);
  end

  // Output gating: idle until counting has started.
  always_comb begin
    hsync      = started && hs_win;
    vsync      = started && vs_win;
    burst_gate = started && burst_win;
    active     = started && h_win && v_win && !hforce && !vs_win;
    blank      = !active;
  end

endmodule

// File: rtl/vtg_timer.sv
module vtg_timer
  import vtg_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_line_len,
  input  logic [HW-1:0] cfg_hsync_w,
  input  logic [HW-1:0] cfg_burst_start,
  input  logic [HW-1:0] cfg_burst_w,
  input  logic [HW-1:0] cfg_hact_ofs,
  input  logic [HW-1:0] cfg_hact_len,
  input  logic [VW-1:0] cfg_field_lines,
  input  logic [VW-1:0] cfg_vact_ofs,
  input  logic [VW-1:0] cfg_vact_len,
  input  logic          cfg_vsync_3l,
  output logic          hsync,
  output logic          vsync,
  output logic          burst_gate,
  output logic          blank,
  output logic          active,
  output logic          field,
  output logic [HW-1:0] pix_cnt,
  output logic [VW-1:0] line_cnt
);

  logic          rst_n_int;
  logic          started;
  logic          field_start;
  logic [HW-1:0] sh_line_len, sh_hsync_w, sh_burst_start, sh_burst_w;
  logic [HW-1:0] sh_hact_ofs, sh_hact_len;
  logic [VW-1:0] sh_field_lines, sh_vact_ofs, sh_vact_len;
  logic          sh_vsync_3l;

  vtg_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  vtg_cfg_shadow #(.HW(HW), .VW(VW)) u_shadow (
    .clk             (clk),
    .rst_n           (rst_n_int),
    .load            (field_start),
    .cfg_line_len    (cfg_line_len),
    .cfg_hsync_w     (cfg_hsync_w),
    .cfg_burst_start (cfg_burst_start),
    .cfg_burst_w     (cfg_burst_w),
    .cfg_hact_ofs    (cfg_hact_ofs),
    .cfg_hact_len    (cfg_hact_len),
    .cfg_field_lines (cfg_field_lines),
    .cfg_vact_ofs    (cfg_vact_ofs),
    .cfg_vact_len    (cfg_vact_len),
    .cfg_vsync_3l    (cfg_vsync_3l),
    .q_line_len      (sh_line_len),
    .q_hsync_w       (sh_hsync_w),
    .q_burst_start   (sh_burst_start),
    .q_burst_w       (sh_burst_w),
    .q_hact_ofs      (sh_hact_ofs),
    .q_hact_len      (sh_hact_len),
    .q_field_lines   (sh_field_lines),
    .q_vact_ofs      (sh_vact_ofs),
    .q_vact_len      (sh_vact_len),
    .q_vsync_3l      (sh_vsync_3l)
  );

  vtg_counters #(.HW(HW), .VW(VW)) u_counters (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .q_line_len    (sh_line_len),
    .q_field_lines (sh_field_lines),
    .started       (started),
    .field_start   (field_start),
    .pix           (pix_cnt),
    .line          (line_cnt),
    .field         (field)
  );

  vtg_decode #(.HW(HW), .VW(VW)) u_decode (
    .started       (started),
    .pix           (pix_cnt),
    .line          (line_cnt),
    .field         (field),
    .q_line_len    (sh_line_len),
    .q_hsync_w     (sh_hsync_w),
    .q_burst_start (sh_burst_start),
    .q_burst_w     (sh_burst_w),
    .q_hact_ofs    (sh_hact_ofs),
    .q_hact_len    (sh_hact_len),
    .q_vact_ofs    (sh_vact_ofs),
    .q_vact_len    (sh_vact_len),
    .q_vsync_3l    (sh_vsync_3l),
    .hsync         (hsync),
    .vsync         (vsync),
    .burst_gate    (burst_gate),
    .blank         (blank),
    .active        (active)
  );

endmodule

// File: rtl/vtg_timer_chk.sv
module vtg_timer_chk #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          started,
  input logic [HW-1:0] pix_cnt,
  input logic [VW-1:0] line_cnt,
  input logic          field,
  input logic          hsync,
  input logic          vsync,
  input logic          burst_gate,
  input logic          blank,
  input logic          active,
  input logic [HW-1:0] q_line_len,
  input logic [HW-1:0] q_hsync_w,
  input logic [HW-1:0] q_burst_start,
  input logic [HW-1:0] q_burst_w,
  input logic [VW-1:0] q_vact_ofs,
  input logic          q_vsync_3l
);

  logic [HW-1:0] half_len;
  logic [HW:0]   burst_stop;

  assign half_len   = {1'b0, q_line_len[HW-1:1]};
  assign burst_stop = {1'b0, q_burst_start} + {1'b0, q_burst_w};

  a_r1_pix_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(started) && pix_cnt != '0) |-> (pix_cnt == $past(pix_cnt) + 1'b1));

  a_r1_pix_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (pix_cnt < q_line_len));

  a_r2_hsync_window: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> (pix_cnt < q_hsync_w));

  a_r3_burst_window: assert property (@(posedge clk) disable iff (!rst_n)
    burst_gate |-> (pix_cnt >= q_burst_start));

  a_r4_vsync_lines: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> (line_cnt <= 3));

  a_r5_short_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !q_vsync_3l && !field && line_cnt == 2) |-> (pix_cnt < half_len));

  a_r6_field_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(started) && pix_cnt == '0 && line_cnt == '0) |-> (field != $past(field)));

  a_r7_force_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (started && ({1'b0, pix_cnt} < burst_stop)) |-> (blank && !active));

  a_r8_vsync_blank: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> (blank && !active));

  a_r9_active_lines: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (line_cnt >= q_vact_ofs));

  a_r10_hold_in_field: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !(pix_cnt == '0 && line_cnt == '0)) |-> $stable(q_line_len));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (blank && !hsync && !vsync && !burst_gate && !active));

endmodule

bind vtg_timer vtg_timer_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .started       (started),
  .pix_cnt       (pix_cnt),
  .line_cnt      (line_cnt),
  .field         (field),
  .hsync         (hsync),
  .vsync         (vsync),
  .burst_gate    (burst_gate),
  .blank         (blank),
  .active        (active),
  .q_line_len    (sh_line_len),
  .q_hsync_w     (sh_hsync_w),
  .q_burst_start (sh_burst_start),
  .q_burst_w     (sh_burst_w),
  .q_vact_ofs    (sh_vact_ofs),
  .q_vsync_3l    (sh_vsync_3l)
);

// File: tb/vtg_timer_tb.sv
`timescale 1ns/1ps
module vtg_timer_tb;

  localparam int HW = 12;
  localparam int VW = 10;

  logic          clk;
  logic          rst_n;
  logic [HW-1:0] cfg_line_len, cfg_hsync_w, cfg_burst_start, cfg_burst_w;
  logic [HW-1:0] cfg_hact_ofs, cfg_hact_len;
  logic [VW-1:0] cfg_field_lines, cfg_vact_ofs, cfg_vact_len;
  logic          cfg_vsync_3l;
  logic          hsync, vsync, burst_gate, blank, active, field;
  logic [HW-1:0] pix_cnt;
  logic [VW-1:0] line_cnt;

  vtg_timer #(.HW(HW), .VW(VW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_line_len(cfg_line_len), .cfg_hsync_w(cfg_hsync_w),
    .cfg_burst_start(cfg_burst_start), .cfg_burst_w(cfg_burst_w),
    .cfg_hact_ofs(cfg_hact_ofs), .cfg_hact_len(cfg_hact_len),
    .cfg_field_lines(cfg_field_lines), .cfg_vact_ofs(cfg_vact_ofs),
    .cfg_vact_len(cfg_vact_len), .cfg_vsync_3l(cfg_vsync_3l),
    .hsync(hsync), .vsync(vsync), .burst_gate(burst_gate), .blank(blank),
    .active(active), .field(field), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  // Applied timing values (what the bench drives).
  int c_L, c_hw, c_bs, c_bw, c_ho, c_ha, c_fl, c_vo, c_va, c_v3;
  // Model copies latched at field start.
  int s_L, s_hw, s_bs, s_bw, s_ho, s_ha, s_fl, s_vo, s_va, s_v3;
  // Model raster state.
  int m_sync = 0, m_st = 0, m_p = 0, m_l = 0, m_f = 0;

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic set_cfg(int L, int hw, int bs, int bw, int ho, int ha,
                         int fl, int vo, int va, int v3);
    c_L = L; c_hw = hw; c_bs = bs; c_bw = bw; c_ho = ho; c_ha = ha;
    c_fl = fl; c_vo = vo; c_va = va; c_v3 = v3;
    cfg_line_len    = HW'(L);
    cfg_hsync_w     = HW'(hw);
    cfg_burst_start = HW'(bs);
    cfg_burst_w     = HW'(bw);
    cfg_hact_ofs    = HW'(ho);
    cfg_hact_len    = HW'(ha);
    cfg_field_lines = VW'(fl);
    cfg_vact_ofs    = VW'(vo);
    cfg_vact_len    = VW'(va);
    cfg_vsync_3l    = v3[0];
  endtask

  task automatic latch_model();
    s_L = c_L; s_hw = c_hw; s_bs = c_bs; s_bw = c_bw; s_ho = c_ho; s_ha = c_ha;
    s_fl = c_fl; s_vo = c_vo; s_va = c_va; s_v3 = c_v3;
  endtask

  // Model advance for one rising edge (R1, R6, R10, R11).
  task automatic model_step();
    if (!rst_n) begin
      m_sync = 0; m_st = 0; m_p = 0; m_l = 0; m_f = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else if (!m_st) begin
      m_st = 1; latch_model(); m_p = 0; m_l = 0; m_f = 0;
    end else if (m_p == s_L - 1) begin
      m_p = 0;
      if (m_l == s_fl - 1) begin
        m_l = 0; m_f ^= 1; latch_model();
      end else begin
        m_l++;
      end
    end else begin
      m_p++;
    end
  endtask

  task automatic chk(string tag, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (field %0d line %0d pix %0d)",
               tag, nm, act, exp, m_f, m_l, m_p);
    end
  endtask

  task automatic compare();
    int e_hs, e_vs, e_bg, e_act, hidx, vs_len, hforce, hwin, vwin;
    string ptag;
    if (!m_st) begin
      chk("R11", "blank", int'(blank), 1);
      chk("R11", "hsync", int'(hsync), 0);
      chk("R11", "vsync", int'(vsync), 0);
      chk("R11", "burst_gate", int'(burst_gate), 0);
      chk("R11", "active", int'(active), 0);
      chk("R11", "field", int'(field), 0);
      chk("R11", "pix_cnt", int'(pix_cnt), 0);
      chk("R11", "line_cnt", int'(line_cnt), 0);
    end else begin
      e_hs   = (m_p < s_hw) ? 1 : 0;
      e_bg   = (m_p >= s_bs && m_p < s_bs + s_bw) ? 1 : 0;
      hidx   = 2 * m_l + ((m_p >= s_L / 2) ? 1 : 0);
      vs_len = s_v3 ? 6 : 5;
      e_vs   = (hidx >= m_f && hidx < m_f + vs_len) ? 1 : 0;
      hforce = (m_p < s_hw || m_p < s_bs + s_bw) ? 1 : 0;
      hwin   = (m_p >= s_ho && m_p < s_ho + s_ha) ? 1 : 0;
      vwin   = (m_l >= s_vo && m_l < s_vo + s_va) ? 1 : 0;
      e_act  = (hwin && vwin && !hforce && !e_vs) ? 1 : 0;
      ptag   = (c_L != s_L || c_fl != s_fl) ? "R10" : "R1";
      chk(ptag, "pix_cnt", int'(pix_cnt), m_p);
      chk(ptag, "line_cnt", int'(line_cnt), m_l);
      chk("R6", "field", int'(field), m_f);
      chk("R2", "hsync", int'(hsync), e_hs);
      chk("R3", "burst_gate", int'(burst_gate), e_bg);
      chk(s_v3 ? "R4" : "R5", "vsync", int'(vsync), e_vs);
      if (hforce)    chk("R7", "active", int'(active), 0);
      else if (e_vs) chk("R8", "active", int'(active), 0);
      else           chk("R9", "active", int'(active), e_act);
      chk("R9", "blank", int'(blank), 1 - e_act);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    // Config A: 3-line vsync, window overlapping the burst region.
    set_cfg(20, 3, 5, 3, 6, 10, 9, 4, 4, 1);
    tick(4);                       // R11: idle under reset
    rst_n = 1'b1;                  // released at a falling edge
    tick(3 + 4 * 180);
    // Config B mid-field (R10): odd line, 2.5-line vsync, window past line end.
    tick(37);
    set_cfg(17, 2, 4, 2, 3, 20, 11, 0, 11, 0);
    tick(180 + 4 * 187);
    // Config C: empty horizontal window.
    set_cfg(24, 4, 6, 4, 12, 0, 8, 2, 3, 1);
    tick(187 + 4 * 192);
    // Config D: hsync wider than the burst end, odd-line 2.5-line vsync.
    set_cfg(15, 6, 3, 1, 0, 15, 7, 1, 6, 0);
    tick(192 + 5 * 105);
    // Reset in mid-run returns to idle (R11).
    @(negedge clk);
    rst_n = 1'b0;
    m_sync = 0; m_st = 0; m_p = 0; m_l = 0; m_f = 0;
    #1;
    compare();
    tick(3);
    rst_n = 1'b1;
    tick(3 + 2 * 105);
    finish_run();
  end

endmodule